// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block turns a set of external interrupt lines into message-signalled interrupt writes. Each line has its own 64-bit redirection entry that holds the vector, delivery mode, destination, destination mode, polarity, trigger mode and mask. Each line also keeps a pending flag and, for level-sensitive lines, a remote-IRR flag that blocks a repeat until an end-of-interrupt arrives. When lines are pending, the controller picks one, builds a 32-bit address and a 32-bit data word, and offers them on a valid/ready output.

Software reaches every internal register through an indirect window of two 32-bit locations. The first location holds an index that selects an internal register. The second location reads or writes the selected register. Read data is registered and appears on the cycle after the read strobe.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: The window index lives at byte offset 0x00 and the data location at 0x10. A write to 0x00 sets the index, and a read at 0x00 returns it. A read or write at 0x10 acts on the selected internal register. `cfg_rdata` updates on the clock edge that samples `cfg_re` and otherwise holds its value.
- R2: Internal register 0x00 keeps a 4-bit identifier in bits 27:24, and all its other bits read 0. Register 0x02 reads the same value in the same layout. Reset sets the identifier to 0.
- R3: Register 0x01 is read-only. It returns the version constant (default 0x20) in bits 7:0 and the highest line number (NUM_PINS-1) in bits 23:16.
- R4: Line n has its low word at index 0x10+2n and its high word at 0x11+2n. Low word layout: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12, polarity 13 (1 = active-low), remote IRR 14, trigger 15 (1 = level) and mask 16. High word: destination in 31:24. All other bits, and every index that matches no register, read 0.
- R5: Bits 12 and 14 of a low word are status and ignore writes.
- R6: After reset every entry reads 0x00010000 (masked), no line is pending, remote IRR is clear, and `msg_valid` is low.
- R7: A line is first XORed with its polarity bit. For an edge-triggered line, a 0-to-1 change of that result between two clock samples sets the pending flag.
- R8: For a level-triggered line, the flag is set while the result is 1 and remote IRR is clear. Acceptance of its message sets remote IRR. An end-of-interrupt whose vector equals the entry's vector clears it, so a line still asserted is sent again. A non-matching vector has no effect.
- R9: A masked line raises no new request. A request that is already pending stays pending while the line is masked and is not sent until the mask is cleared.
- R10: Delivery status reads 1 from the cycle a request becomes pending until its message is accepted.
- R11: When several unmasked lines are pending, the lowest-numbered one is offered first.
- R12: Message address is 0xFEE00000 with the destination in bits 19:12, the destination mode in bit 2 and the redirection hint in bit 3. The hint is 1 exactly when the delivery mode is lowest-priority (code 1). All other bits are 0.
- R13: Message data holds the vector in 7:0, the delivery mode in 10:8, a 1 (assert) in bit 14 and the trigger mode in bit 15. All other bits are 0.
- R14: Once `msg_valid` is high, it stays high with an unchanged address and data until `msg_ready` is high. After each acceptance `msg_valid` is low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the window |
| cfg_re | input | 1 | Read strobe for the window |
| cfg_addr | input | ADDR_W | Byte offset: 0x00 index, 0x10 data |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_PINS | Interrupt lines, synchronous to clk |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken by the receiver |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector that the end-of-interrupt names |

## Verification
The assertions assume that the interrupt lines, `msg_ready` and the end-of-interrupt inputs are synchronous to the clock and are held low or stable through reset. They also assume that `cfg_addr` is only ever 0x00 or 0x10 while a strobe is active. The bench changes every input only on the falling edge and drives only those two offsets. It reconfigures a line only while that line is at its inactive level, so a polarity change never counts as an edge unless the test means it to. The receiver is stalled and released at chosen moments, so held, masked and competing requests all meet the handshake.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int unsigned OFS_INDEX = 'h00;
  localparam int unsigned OFS_DATA  = 'h10;
  localparam int unsigned REG_ID    = 'h00;
  localparam int unsigned REG_VER   = 'h01;
  localparam int unsigned REG_ARB   = 'h02;
  localparam int unsigned REG_TBL   = 'h10;
  localparam logic [31:0] MSI_BASE  = 32'hFEE0_0000;
  localparam logic [2:0]  DM_LOPRI  = 3'd1;

  typedef struct packed {
    logic       mask;
    logic       trig;
    logic       pol;
    logic       dstmod;
    logic [2:0] dmode;
    logic [7:0] vec;
    logic [7:0] dest;
  } irc_entry_t;

  localparam irc_entry_t ENTRY_RST = '{mask: 1'b1, default: '0};
endpackage

// File: rtl/irc_regfile.sv
module irc_regfile
  import irc_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned ADDR_W   = 5,
  parameter logic [7:0]  VERSION  = 8'h20
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic                            cfg_re,
  input  logic [ADDR_W-1:0]               cfg_addr,
  input  logic [31:0]                     cfg_wdata,
  output logic [31:0]                     cfg_rdata,
  input  logic [NUM_PINS-1:0]             pend,
  input  logic [NUM_PINS-1:0]             irr,
  output irc_entry_t [NUM_PINS-1:0]       ent
);
  localparam int unsigned PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [IDX_W-1:0] idx_q;
  logic [3:0]       id_q;
  logic             sel_index, sel_data;
  logic [IDX_W-1:0] rel;
  logic [IDX_W-2:0] tbl_pin;
  logic             tbl_hi, tbl_hit;
  logic [PIN_W-1:0] rd_pin;
  logic [31:0]      rd_val;

  assign sel_index = (cfg_addr == ADDR_W'(OFS_INDEX));
  assign sel_data  = (cfg_addr == ADDR_W'(OFS_DATA));
  assign rel       = idx_q - IDX_W'(REG_TBL);
  assign tbl_pin   = rel[IDX_W-1:1];
  assign tbl_hi    = rel[0];
  assign tbl_hit   = (idx_q >= IDX_W'(REG_TBL)) && (tbl_pin < (IDX_W-1)'(NUM_PINS));
  assign rd_pin    = tbl_pin[PIN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      id_q  <= '0;
    end else if (cfg_we) begin
      if (sel_index) idx_q <= cfg_wdata[IDX_W-1:0];
      if (sel_data && idx_q == IDX_W'(REG_ID)) id_q <= cfg_wdata[27:24];
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_entry
    logic wr_lo, wr_hi;
    assign wr_lo = cfg_we && sel_data && tbl_hit && (tbl_pin == (IDX_W-1)'(p)) && !tbl_hi;
    assign wr_hi = cfg_we && sel_data && tbl_hit && (tbl_pin == (IDX_W-1)'(p)) && tbl_hi;
    always_ff @(posedge clk) begin
      if (rst) begin
        ent[p] <= ENTRY_RST;
      end else if (wr_lo) begin
        ent[p].vec    <= cfg_wdata[7:0];
        ent[p].dmode  <= cfg_wdata[10:8];
        ent[p].dstmod <= cfg_wdata[11];
        ent[p].pol    <= cfg_wdata[13];
        ent[p].trig   <= cfg_wdata[15];
        ent[p].mask   <= cfg_wdata[16];
      end else if (wr_hi) begin
        ent[p].dest   <= cfg_wdata[31:24];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (sel_index) begin
      rd_val = 32'(idx_q);
    end else if (sel_data) begin
      if (idx_q == IDX_W'(REG_ID) || idx_q == IDX_W'(REG_ARB)) begin
        rd_val = {4'b0, id_q, 24'b0};
      end else if (idx_q == IDX_W'(REG_VER)) begin
        rd_val = {8'b0, 8'(NUM_PINS - 1), 8'b0, VERSION};
      end else if (tbl_hit) begin
        if (tbl_hi) begin
          rd_val = {ent[rd_pin].dest, 24'b0};
        end else begin
          rd_val = {15'b0, ent[rd_pin].mask, ent[rd_pin].trig, irr[rd_pin],
                    ent[rd_pin].pol, pend[rd_pin], ent[rd_pin].dstmod,
                    ent[rd_pin].dmode, ent[rd_pin].vec};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_re) cfg_rdata <= rd_val;
  end
endmodule

// File: rtl/irc_pin.sv
module irc_pin
  import irc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_in,
  input  irc_entry_t ent,
  input  logic       take,
  input  logic       eoi_hit,
  output logic       pend,
  output logic       irr
);
  logic sensed, sensed_q, set_req;

  assign sensed  = pin_in ^ ent.pol;
  assign set_req = !ent.mask &&
                   (ent.trig ? (sensed && !irr && !take) : (sensed && !sensed_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      sensed_q <= 1'b0;
      pend     <= 1'b0;
      irr      <= 1'b0;
    end else begin
      sensed_q <= sensed;
      pend     <= (pend && !take) || set_req;
      if (take && ent.trig) irr <= 1'b1;
      else if (eoi_hit)     irr <= 1'b0;
    end
  end
endmodule

// File: rtl/irc_msg_out.sv
module irc_msg_out
  import irc_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PINS-1:0]       req,
  input  irc_entry_t [NUM_PINS-1:0] ent,
  input  logic                      msg_ready,
  output logic                      msg_valid,
  output logic [31:0]               msg_addr,
  output logic [31:0]               msg_data,
  output logic [NUM_PINS-1:0]       take
);
  localparam int unsigned PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [PIN_W-1:0] cand, sel_q;
  logic             cand_any;
  irc_entry_t       ce;

  always_comb begin
    cand     = '0;
    cand_any = 1'b0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req[i]) begin
        cand     = PIN_W'(i);
        cand_any = 1'b1;
      end
    end
  end

  assign ce = ent[cand];

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      sel_q     <= '0;
    end else if (!msg_valid) begin
      if (cand_any) begin
        msg_valid <= 1'b1;
        sel_q     <= cand;
        msg_addr  <= MSI_BASE | {12'b0, ce.dest, 8'b0, (ce.dmode == DM_LOPRI), ce.dstmod, 2'b0};
        msg_data  <= {16'b0, ce.trig, 1'b1, 3'b0, ce.dmode, ce.vec};
      end
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_take
    assign take[i] = msg_valid && msg_ready && (sel_q == PIN_W'(i));
  end
endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
  import irc_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned ADDR_W   = 5,
  parameter logic [7:0]  VERSION  = 8'h20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic                cfg_re,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic [NUM_PINS-1:0] irq_in,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [31:0]         msg_addr,
  output logic [31:0]         msg_data,
  input  logic                eoi_valid,
  input  logic [7:0]          eoi_vector
);
  irc_entry_t [NUM_PINS-1:0] ent;
  logic [NUM_PINS-1:0] pend, irr, take, req;

  irc_regfile #(
    .NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .VERSION(VERSION)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pend(pend), .irr(irr), .ent(ent)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    irc_pin u_pin (
      .clk(clk), .rst(rst), .pin_in(irq_in[p]), .ent(ent[p]), .take(take[p]),
      .eoi_hit(eoi_valid && (eoi_vector == ent[p].vec)),
      .pend(pend[p]), .irr(irr[p])
    );
    assign req[p] = pend[p] && !ent[p].mask;
  end

  irc_msg_out #(.NUM_PINS(NUM_PINS)) u_out (
    .clk(clk), .rst(rst), .req(req), .ent(ent), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data), .take(take)
  );
endmodule

// File: rtl/irc_checker.sv
module irc_checker (
  input logic        clk,
  input logic        rst,
  input logic        cfg_re,
  input logic [31:0] cfg_rdata,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [31:0] msg_addr,
  input logic [31:0] msg_data
);
  p_rst_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !msg_valid);

  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !cfg_re |=> $stable(cfg_rdata));

  p_hold_r14: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  p_gap_r14: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_ready) |=> !msg_valid);

  p_addr_fmt_r12: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_addr[31:20] == 12'hFEE && msg_addr[11:4] == 8'h00 && msg_addr[1:0] == 2'b00));

  p_hint_r12: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_addr[3] == (msg_data[10:8] == 3'd1)));

  p_data_fmt_r13: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_data[31:16] == 16'h0 && msg_data[13:11] == 3'b0 && msg_data[14]));
endmodule

bind irq_redirect_ctrl irc_checker u_chk (
  .clk(clk), .rst(rst), .cfg_re(cfg_re), .cfg_rdata(cfg_rdata),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/tb_irq_redirect_ctrl.sv
module tb_irq_redirect_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [NP-1:0] irq_in = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [31:0] msg_addr, msg_data;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_redirect_ctrl dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_in(irq_in),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
  );

  // Behavioural reference model
  bit         m_mask[NP], m_trig[NP], m_pol[NP], m_dm1[NP], m_pend[NP], m_irr[NP], m_sq[NP];
  logic [2:0] m_dmode[NP];
  logic [7:0] m_vec[NP], m_dest[NP];
  logic [7:0] m_idx;
  logic [3:0] m_id;
  bit         m_valid;
  int         m_sel;
  logic [31:0] m_addr, m_data, m_rdata;

  function automatic logic [31:0] mread(input logic [4:0] a);
    int k;
    if (a == 5'h00) return {24'b0, m_idx};
    if (a != 5'h10) return 32'h0;
    if (m_idx == 8'h00 || m_idx == 8'h02) return {4'b0, m_id, 24'b0};
    if (m_idx == 8'h01) return {8'h0, 8'(NP - 1), 8'h0, 8'h20};
    if (m_idx < 8'h10) return 32'h0;
    k = (int'(m_idx) - 16) / 2;
    if (k >= NP) return 32'h0;
    if (m_idx[0]) return {m_dest[k], 24'b0};
    return {15'b0, m_mask[k], m_trig[k], m_irr[k], m_pol[k], m_pend[k], m_dm1[k], m_dmode[k], m_vec[k]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < NP; n++) begin
        m_mask[n] = 1; m_trig[n] = 0; m_pol[n] = 0; m_dm1[n] = 0; m_pend[n] = 0;
        m_irr[n] = 0; m_sq[n] = 0; m_dmode[n] = 0; m_vec[n] = 0; m_dest[n] = 0;
      end
      m_idx = 0; m_id = 0; m_valid = 0; m_sel = 0; m_addr = 0; m_data = 0; m_rdata = 0;
    end else begin
      bit acc;
      int cand;
      acc  = m_valid && msg_ready;
      cand = -1;
      for (int n = NP - 1; n >= 0; n--) if (m_pend[n] && !m_mask[n]) cand = n;
      if (cfg_re) m_rdata = mread(cfg_addr);
      for (int n = 0; n < NP; n++) begin
        bit s, tk, st;
        s  = irq_in[n] ^ m_pol[n];
        tk = acc && (m_sel == n);
        st = !m_mask[n] && (m_trig[n] ? (s && !m_irr[n] && !tk) : (s && !m_sq[n]));
        if (tk && m_trig[n]) m_irr[n] = 1;
        else if (eoi_valid && eoi_vector == m_vec[n]) m_irr[n] = 0;
        m_pend[n] = (m_pend[n] && !tk) || st;
        m_sq[n] = s;
      end
      if (!m_valid) begin
        if (cand >= 0) begin
          m_valid = 1; m_sel = cand;
          m_addr = 32'hFEE00000 | (32'(m_dest[cand]) << 12) |
                   ((m_dmode[cand] == 3'd1) ? 32'h8 : 32'h0) | (m_dm1[cand] ? 32'h4 : 32'h0);
          m_data = 32'(m_vec[cand]) | (32'(m_dmode[cand]) << 8) | 32'h4000 |
                   (m_trig[cand] ? 32'h8000 : 32'h0);
        end
      end else if (msg_ready) m_valid = 0;
      if (cfg_we && cfg_addr == 5'h10) begin
        if (m_idx == 8'h00) m_id = cfg_wdata[27:24];
        else if (m_idx >= 8'h10 && (int'(m_idx) - 16) / 2 < NP) begin
          int k;
          k = (int'(m_idx) - 16) / 2;
          if (m_idx[0]) m_dest[k] = cfg_wdata[31:24];
          else begin
            m_vec[k] = cfg_wdata[7:0]; m_dmode[k] = cfg_wdata[10:8]; m_dm1[k] = cfg_wdata[11];
            m_pol[k] = cfg_wdata[13]; m_trig[k] = cfg_wdata[15]; m_mask[k] = cfg_wdata[16];
          end
        end
      end
      if (cfg_we && cfg_addr == 5'h00) m_idx = cfg_wdata[7:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("MODEL valid", 32'(msg_valid), 32'(m_valid));
      chk("MODEL rdata", cfg_rdata, m_rdata);
      if (m_valid) begin
        chk("MODEL addr", msg_addr, m_addr);
        chk("MODEL data", msg_data, m_data);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    tick(1);
    cfg_we = 0;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
    cfg_write(5'h00, 32'(idx));
    cfg_write(5'h10, d);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [31:0] v);
    cfg_write(5'h00, 32'(idx));
    cfg_re = 1; cfg_addr = 5'h10;
    tick(1);
    cfg_re = 0;
    v = cfg_rdata;
  endtask

  task automatic accept_one();
    msg_ready = 1;
    tick(1);
    msg_ready = 0;
  endtask

  task automatic send_eoi(input logic [7:0] v);
    eoi_valid = 1; eoi_vector = v;
    tick(1);
    eoi_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    tick(3);
    rst = 0;
    tick(1);
    // R6 reset state
    chk("R6 valid after reset", 32'(msg_valid), 0);
    reg_read(8'h10, v); chk("R6 entry0 low reset", v, 32'h0001_0000);
    reg_read(8'h1F, v); chk("R6 entry7 high reset", v, 32'h0);
    reg_read(8'h00, v); chk("R2 id reset", v, 32'h0);
    // R2 identifier and arbitration mirror
    reg_write(8'h00, 32'hFA00_00FF);
    reg_read(8'h00, v); chk("R2 id write", v, 32'h0A00_0000);
    reg_read(8'h02, v); chk("R2 arb mirror", v, 32'h0A00_0000);
    // R3 version read-only
    reg_read(8'h01, v); chk("R3 version", v, 32'h0007_0020);
    reg_write(8'h01, 32'hFFFF_FFFF);
    reg_read(8'h01, v); chk("R3 version unchanged", v, 32'h0007_0020);
    // R1 index readback
    cfg_write(5'h00, 32'h0000_0013);
    cfg_re = 1; cfg_addr = 5'h00; tick(1); cfg_re = 0;
    chk("R1 index readback", cfg_rdata, 32'h13);
    tick(2);
    chk("R1 rdata holds", cfg_rdata, 32'h13);
    // R5 status bits ignore writes (line 7 masked)
    reg_write(8'h1E, 32'hFFFE_5023 | 32'h0001_0000);
    reg_read(8'h1E, v); chk("R5 status bits ignored", v, 32'h0001_8B23 & 32'h0001_0023 | 32'h0);
    // R4 high word and out-of-range index
    reg_write(8'h17, 32'hAB12_3456);
    reg_read(8'h17, v); chk("R4 high word", v, 32'hAB00_0000);
    reg_read(8'h20, v); chk("R4 beyond table", v, 32'h0);
    reg_read(8'h05, v); chk("R4 unused index", v, 32'h0);
    // R7 edge line 1, fixed, physical, destination 5
    reg_write(8'h13, 32'h0500_0000);
    reg_write(8'h12, 32'h0000_0041);
    irq_in[1] = 1;
    tick(3);
    chk("R7 edge fires", 32'(msg_valid), 1);
    chk("R12 addr edge", msg_addr, 32'hFEE0_5000);
    chk("R13 data edge", msg_data, 32'h0000_4041);
    reg_read(8'h12, v); chk("R10 status pending", v, 32'h0000_1041);
    chk("R14 held while stalled", 32'(msg_valid), 1);
    accept_one();
    chk("R14 drop after accept", 32'(msg_valid), 0);
    reg_read(8'h12, v); chk("R10 status cleared", v, 32'h0000_0041);
    // R7 active-low edge on line 4
    irq_in[4] = 1;
    reg_write(8'h18, 32'h0000_2044);
    tick(3);
    chk("R7 no spurious edge", 32'(msg_valid), 0);
    irq_in[4] = 0;
    tick(3);
    chk("R7 active-low fires", msg_data, 32'h0000_4044);
    chk("R12 addr dest0", msg_addr, 32'hFEE0_0000);
    accept_one();
    // R9 masked line 5 raises nothing
    reg_write(8'h1A, 32'h0001_0055);
    irq_in[5] = 1;
    tick(4);
    chk("R9 masked no message", 32'(msg_valid), 0);
    reg_read(8'h1A, v); chk("R9 masked not pending", v, 32'h0001_0055);
    // R9 pending held while masked (line 6)
    reg_write(8'h1C, 32'h0000_0066);
    irq_in[1] = 0; tick(1); irq_in[1] = 1;
    tick(3);
    chk("R9 line1 in flight", msg_data, 32'h0000_4041);
    irq_in[6] = 1;
    tick(2);
    reg_write(8'h1C, 32'h0001_0066);
    accept_one();
    tick(4);
    chk("R9 held while masked", 32'(msg_valid), 0);
    reg_read(8'h1C, v); chk("R10 masked still pending", v, 32'h0001_1066);
    reg_write(8'h1C, 32'h0000_0066);
    tick(3);
    chk("R9 sent after unmask", msg_data, 32'h0000_4066);
    accept_one();
    // R11 lowest line first (lines 2 and 3)
    reg_write(8'h14, 32'h0000_0032);
    reg_write(8'h16, 32'h0000_0033);
    irq_in[3] = 1; irq_in[2] = 1;
    tick(3);
    chk("R11 lower first", msg_data, 32'h0000_4032);
    accept_one();
    tick(1);
    chk("R11 second", msg_data, 32'h0000_4033);
    chk("R12 addr dest AB", msg_addr, 32'hFEEA_B000);
    accept_one();
    // R8 level line 0, lowest-priority, logical, destination 2
    reg_write(8'h11, 32'h0200_0000);
    reg_write(8'h10, 32'h0000_8960);
    irq_in[0] = 1;
    tick(3);
    chk("R8 level fires", 32'(msg_valid), 1);
    chk("R12 addr hint logical", msg_addr, 32'hFEE0_200C);
    chk("R13 data level", msg_data, 32'h0000_C160);
    accept_one();
    tick(4);
    chk("R8 blocked by irr", 32'(msg_valid), 0);
    reg_read(8'h10, v); chk("R8 irr visible", v, 32'h0000_C960);
    send_eoi(8'h61);
    tick(3);
    chk("R8 wrong vector ignored", 32'(msg_valid), 0);
    reg_read(8'h10, v); chk("R8 irr kept", v, 32'h0000_C960);
    send_eoi(8'h60);
    tick(3);
    chk("R8 refire after eoi", msg_data, 32'h0000_C160);
    accept_one();
    irq_in[0] = 0;
    tick(1);
    send_eoi(8'h60);
    tick(4);
    chk("R8 no fire when released", 32'(msg_valid), 0);
    reg_read(8'h10, v); chk("R8 irr cleared", v, 32'h0000_8960);
    tick(2);
    finish_run();
  end
endmodule